// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog with a two-stage timeout policy. Software programs a timeout in ticks and starts the countdown by clearing a halt bit. Each pulse on `tickEn` moves the count down by one. The first expiry records a status bit, optionally raises a one-cycle SMI pulse, reloads the count and keeps running. A second expiry in a row, with no reload write in between, sets the second-stage status bits. It then asks for a reboot, unless a strap input or a no-reboot control holds it off.

A small mailbox sits next to the timer. Writing its inbound byte always raises SMI. Writing its outbound byte flags an interrupt status bit. Register access is halfword-wide with two byte enables and a combinational read port. A lock bit in the first control register can be set by software but cleared only by reset.

Top module: `wdt_two_stage`

## Requirements
- R1: The register map is at halfword offsets in a 32-byte window. The offsets are: 0x00 reload/count, 0x02 mailbox (in-byte [7:0], out-byte [15:8]), 0x04 status A, 0x06 status B, 0x08 control A, 0x0A control B, 0x0C message pair, 0x0E misc (watchdog-count byte [7:0], soft-IRQ byte [15:8]), 0x10 timeout. `byteEn[0]` writes bits [7:0] and `byteEn[1]` writes bits [15:8]. Unmapped offsets read 0.
- R2: After reset, control B reads 0x0008, timeout reads 0x0004 and misc reads 0x0300. Every other register reads 0 and both pulse outputs are low.
- R3: The countdown starts only when control A bit 0 (halt) is clear and the 10-bit timeout value is greater than 1. A timeout of 0 or 1, or a set halt bit, produces no expiry however many ticks arrive.
- R4: After exactly timeout-many ticks, the timer expires. The expiry sets status A bit 0, the timer reloads from the timeout register and it keeps counting.
- R5: The second consecutive expiry sets status B bits 0 and 1. If `strapHi` and `noRebootCtl` are both low, `rebootPulse` is high for one cycle, no SMI is raised, the timer stops and the reload register reads 0. If either input is high, the expiry is handled like a first one.
- R6: An expiry that does not reboot pulses `smiPulse` for one cycle only when `smiWdogEn` is high.
- R7: While the timer runs, a read of the reload register returns the remaining ticks in bits [9:0] and the stored bits [15:10].
- R8: A write to the reload register clears the consecutive-expiry count. If the timer may run, the write restarts it from the timeout value. Otherwise the written value is stored and reads back unchanged.
- R9: A write to the mailbox in-byte stores it, sets status A bit 1 and pulses `smiPulse` regardless of `smiWdogEn`.
- R10: A write to the mailbox out-byte stores it and sets status A bit 2, with no SMI.
- R11: Control A bit 1 (lock) stays set until reset, whatever is written to it. Every write to control A restarts the timer if it may run and stops it otherwise.
- R12: When events collide in one cycle, the following rules apply. A status bit set by hardware wins over a software write of 0 to it. An SMI from an expiry and an SMI from a mailbox write together give a single one-cycle pulse. A reload or control-A write in the same cycle as the final tick drops that expiry.
- R13: Status A keeps only bits [2:0] and status B keeps only bits [1:0]. Each is a masked direct write, not write-1-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle count enable from the tick source |
| strapHi | input | 1 | Strap level that holds off reboot when high |
| noRebootCtl | input | 1 | Global control that holds off reboot when high |
| smiWdogEn | input | 1 | Enables SMI on watchdog expiry |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte offset of the addressed halfword |
| byteEn | input | 2 | Byte enables for the write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for regAddr |
| smiPulse | output | 1 | One-cycle SMI request |
| rebootPulse | output | 1 | One-cycle reboot request |

## Verification
A timer expiry and a register write can land on the same clock edge. The bench sets this up by counting ticks down to the last one and issuing the write in the cycle that carries that final tick. With an in-byte mailbox write, the bench expects one SMI pulse that is low again a cycle later, and status A showing both the expiry and the software-SMI bits. With a status A write of 0 it expects the expiry bit to survive. With a reload write it expects no expiry at all and a fresh full count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [REG_ADDR_W-1:0] OFF_RLD  = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFF_MBOX = 5'h02;
  localparam logic [REG_ADDR_W-1:0] OFF_STA  = 5'h04;
  localparam logic [REG_ADDR_W-1:0] OFF_STB  = 5'h06;
  localparam logic [REG_ADDR_W-1:0] OFF_CTA  = 5'h08;
  localparam logic [REG_ADDR_W-1:0] OFF_CTB  = 5'h0A;
  localparam logic [REG_ADDR_W-1:0] OFF_MSG  = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] OFF_MISC = 5'h0E;
  localparam logic [REG_ADDR_W-1:0] OFF_TMR  = 5'h10;

  localparam logic [DATA_W-1:0] CTB_RESET  = 16'h0008;
  localparam logic [7:0]        SIRQ_RESET = 8'h03;

  // strobes from control to datapath
  typedef struct packed {
    logic setTimeout;   // first-level expiry seen
    logic setSecond;    // second consecutive expiry seen
    logic rldLoadTmr;   // copy timeout into stored reload
    logic rldClear;     // clear stored reload (reboot path)
  } wdtStrobe_t;

  function automatic logic [DATA_W-1:0] mergeBytes(
      input logic [DATA_W-1:0] oldV,
      input logic [DATA_W-1:0] newV,
      input logic [1:0]        be);
    mergeBytes = {be[1] ? newV[15:8] : oldV[15:8],
                  be[0] ? newV[7:0]  : oldV[7:0]};
  endfunction
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TMR_RESET = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [1:0]            byteEn,
  input  logic [DATA_W-1:0]     wrData,
  input  wdtStrobe_t            strobe,
  input  logic                  running,
  input  logic [CNT_W-1:0]      curCnt,
  output logic [DATA_W-1:0]     rdData,
  output logic [CNT_W-1:0]      tmrVal,
  output logic                  canRunCur,
  output logic                  canRunNew,
  output logic                  rldWr,
  output logic                  ctaWr,
  output logic                  dinWr
);
  localparam int UP_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] rldQ, ctbQ;
  logic [7:0]        dinQ, doutQ, msgLoQ, msgHiQ, wdcQ, sirqQ;
  logic [2:0]        staQ;
  logic [1:0]        stbQ;
  logic [1:0]        ctaQ, ctaNext;
  logic [CNT_W-1:0]  tmrQ;
  logic [DATA_W-1:0] wrVal;
  logic              anyBe, doutWr;
  logic              hitSta, hitStb, hitCtb, hitMsg, hitMisc, hitTmr;

  assign anyBe   = |byteEn;
  assign hitSta  = wrEn && anyBe && regAddr == OFF_STA;
  assign hitStb  = wrEn && anyBe && regAddr == OFF_STB;
  assign hitCtb  = wrEn && anyBe && regAddr == OFF_CTB;
  assign hitMsg  = wrEn && anyBe && regAddr == OFF_MSG;
  assign hitMisc = wrEn && anyBe && regAddr == OFF_MISC;
  assign hitTmr  = wrEn && anyBe && regAddr == OFF_TMR;
  assign rldWr   = wrEn && anyBe && regAddr == OFF_RLD;
  assign ctaWr   = wrEn && anyBe && regAddr == OFF_CTA;
  assign dinWr   = wrEn && byteEn[0] && regAddr == OFF_MBOX;
  assign doutWr  = wrEn && byteEn[1] && regAddr == OFF_MBOX;

  // read mux, also the base for byte-merged writes
  always_comb begin
    unique case (regAddr)
      OFF_RLD:  rdData = running ? {rldQ[DATA_W-1:CNT_W], curCnt} : rldQ;
      OFF_MBOX: rdData = {doutQ, dinQ};
      OFF_STA:  rdData = DATA_W'(staQ);
      OFF_STB:  rdData = DATA_W'(stbQ);
      OFF_CTA:  rdData = DATA_W'(ctaQ);
      OFF_CTB:  rdData = ctbQ;
      OFF_MSG:  rdData = {msgHiQ, msgLoQ};
      OFF_MISC: rdData = {sirqQ, wdcQ};
      OFF_TMR:  rdData = DATA_W'(tmrQ);
      default:  rdData = '0;
    endcase
  end

  assign wrVal   = mergeBytes(rdData, wrData, byteEn);
  assign ctaNext = {wrVal[1] | ctaQ[1], wrVal[0]};   // lock bit is sticky
  assign tmrVal  = tmrQ;
  assign canRunCur = !ctaQ[0] && (tmrQ > CNT_W'(1));
  assign canRunNew = !ctaNext[0] && (tmrQ > CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rldQ   <= '0;
      dinQ   <= '0;
      doutQ  <= '0;
      staQ   <= '0;
      stbQ   <= '0;
      ctaQ   <= '0;
      ctbQ   <= CTB_RESET;
      msgLoQ <= '0;
      msgHiQ <= '0;
      wdcQ   <= '0;
      sirqQ  <= SIRQ_RESET;
      tmrQ   <= CNT_W'(TMR_RESET);
    end else begin
      if (strobe.rldClear)        rldQ <= '0;
      else if (strobe.rldLoadTmr) rldQ <= DATA_W'(tmrQ);
      else if (rldWr)             rldQ <= wrVal;

      if (dinWr)  dinQ  <= wrData[7:0];
      if (doutWr) doutQ <= wrData[15:8];

      staQ <= (hitSta ? wrVal[2:0] : staQ)
            | {doutWr, dinWr, strobe.setTimeout};
      stbQ <= (hitStb ? wrVal[1:0] : stbQ) | {2{strobe.setSecond}};

      if (ctaWr) ctaQ <= ctaNext;
      if (hitCtb) ctbQ <= wrVal;
      if (hitMsg) {msgHiQ, msgLoQ} <= wrVal;
      if (hitMisc) {sirqQ, wdcQ} <= wrVal;
      if (hitTmr) tmrQ <= wrVal[CNT_W-1:0];
    end
  end

  if (UP_W < 1) begin : g_widthCheck
    initial $error("CNT_W must be below DATA_W");
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             strapHi,
  input  logic             noRebootCtl,
  input  logic             smiWdogEn,
  input  logic             rldWr,
  input  logic             ctaWr,
  input  logic             dinWr,
  input  logic             canRunCur,
  input  logic             canRunNew,
  input  logic [CNT_W-1:0] tmrVal,
  output wdtStrobe_t       strobe,
  output logic             running,
  output logic [CNT_W-1:0] curCnt,
  output logic             smiPulse,
  output logic             rebootPulse
);
  localparam int TO_W = $clog2(STAGES + 1);

  logic [TO_W-1:0] toCnt;
  logic expire, second, rebootFire, smiReq;

  // register writes to reload/control take the cycle; the tick is dropped
  assign expire     = running && tickEn && (curCnt <= CNT_W'(1)) && !rldWr && !ctaWr;
  assign second     = expire && (toCnt == TO_W'(STAGES - 1));
  assign rebootFire = second && !strapHi && !noRebootCtl;
  assign smiReq     = (expire && !rebootFire && smiWdogEn) || dinWr;

  assign strobe.setTimeout = expire;
  assign strobe.setSecond  = second;
  assign strobe.rldClear   = rebootFire;
  assign strobe.rldLoadTmr = (expire && !rebootFire) || (rldWr && canRunCur)
                           || (ctaWr && canRunNew);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCnt      <= '0;
      running     <= 1'b0;
      toCnt       <= '0;
      smiPulse    <= 1'b0;
      rebootPulse <= 1'b0;
    end else begin
      smiPulse    <= smiReq;
      rebootPulse <= rebootFire;
      if (rldWr) begin
        toCnt <= '0;
        if (canRunCur) begin
          curCnt  <= tmrVal;
          running <= 1'b1;
        end
      end else if (ctaWr) begin
        if (canRunNew) begin
          curCnt  <= tmrVal;
          running <= 1'b1;
        end else begin
          running <= 1'b0;
        end
      end else if (running && tickEn) begin
        if (expire) begin
          toCnt <= second ? '0 : toCnt + TO_W'(1);
          if (rebootFire) running <= 1'b0;
          else            curCnt  <= tmrVal;
        end else begin
          curCnt <= curCnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int STAGES = 2,
  parameter int TMR_RESET = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  strapHi,
  input  logic                  noRebootCtl,
  input  logic                  smiWdogEn,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [1:0]            byteEn,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  smiPulse,
  output logic                  rebootPulse
);
  wdtStrobe_t       strobe;
  logic             running, canRunCur, canRunNew, rldWr, ctaWr, dinWr;
  logic [CNT_W-1:0] curCnt, tmrVal;

  wdt_datapath #(.CNT_W(CNT_W), .TMR_RESET(TMR_RESET)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .byteEn(byteEn),
    .wrData(wrData), .strobe(strobe), .running(running), .curCnt(curCnt),
    .rdData(rdData), .tmrVal(tmrVal), .canRunCur(canRunCur),
    .canRunNew(canRunNew), .rldWr(rldWr), .ctaWr(ctaWr), .dinWr(dinWr)
  );

  wdt_ctrl #(.CNT_W(CNT_W), .STAGES(STAGES)) uCtl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strapHi(strapHi),
    .noRebootCtl(noRebootCtl), .smiWdogEn(smiWdogEn), .rldWr(rldWr),
    .ctaWr(ctaWr), .dinWr(dinWr), .canRunCur(canRunCur),
    .canRunNew(canRunNew), .tmrVal(tmrVal), .strobe(strobe),
    .running(running), .curCnt(curCnt), .smiPulse(smiPulse),
    .rebootPulse(rebootPulse)
  );
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk
  import wdt_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  tickEn,
  input logic                  strapHi,
  input logic                  noRebootCtl,
  input logic                  wrEn,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [1:0]            byteEn,
  input logic [DATA_W-1:0]     rdData,
  input logic                  smiPulse,
  input logic                  rebootPulse
);
  AST_REBOOT_HELD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (strapHi || noRebootCtl) |=> !rebootPulse);                          // R5
  AST_REBOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rebootPulse |=> !rebootPulse);                                       // R5
  AST_REBOOT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    rebootPulse |-> $past(tickEn));                                      // R5
  AST_DIN_RAISES_SMI: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && byteEn[0] && regAddr == OFF_MBOX) |=> smiPulse);            // R9
  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFF_CTA && rdData[1]) |=> (regAddr != OFF_CTA || rdData[1])); // R11
endmodule

bind wdt_two_stage wdt_two_stage_chk uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .strapHi(strapHi),
  .noRebootCtl(noRebootCtl), .wrEn(wrEn), .regAddr(regAddr),
  .byteEn(byteEn), .rdData(rdData), .smiPulse(smiPulse),
  .rebootPulse(rebootPulse)
);

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
  import wdt_pkg::*;

  logic clk = 1'b0, rstN = 1'b0;
  logic tickEn = 1'b0, strapHi = 1'b0, noRebootCtl = 1'b0, smiWdogEn = 1'b1;
  logic wrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [1:0] byteEn = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic smiPulse, rebootPulse;
  int nChk = 0, nErr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wdt_two_stage u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strapHi(strapHi),
    .noRebootCtl(noRebootCtl), .smiWdogEn(smiWdogEn), .wrEn(wrEn),
    .regAddr(regAddr), .byteEn(byteEn), .wrData(wrData), .rdData(rdData),
    .smiPulse(smiPulse), .rebootPulse(rebootPulse)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  // one cycle: optional write, optional tick; pulses of that edge visible on return
  task automatic step(input bit doWr, input logic [4:0] a, input logic [15:0] d,
                      input logic [1:0] be, input bit tk);
    @(negedge clk);
    wrEn = doWr; regAddr = a; wrData = d; byteEn = doWr ? be : 2'b00; tickEn = tk;
    @(negedge clk);
    wrEn = 1'b0; byteEn = 2'b00; tickEn = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    step(1'b1, a, d, be, 1'b0);
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic ticks(input int n, output int smiN, output int rebN);
    smiN = 0; rebN = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b0, '0, '0, 2'b00, 1'b1);
      smiN += int'(smiPulse);
      rebN += int'(rebootPulse);
    end
  endtask

  task automatic testReset();
    logic [15:0] v;
    rd(OFF_TMR, v);  check("R2 timeout reset", v, 16'h0004);
    rd(OFF_CTB, v);  check("R2 control B reset", v, 16'h0008);
    rd(OFF_MISC, v); check("R2 misc reset", v, 16'h0300);
    rd(OFF_RLD, v);  check("R2 reload reset", v, 16'h0000);
    rd(OFF_STA, v);  check("R2 status A reset", v, 16'h0000);
    check("R2 pulses low", {14'b0, smiPulse, rebootPulse}, 16'h0);
  endtask

  task automatic testMap();
    logic [15:0] v;
    wr(OFF_MSG, 16'hA55A);
    rd(OFF_MSG, v); check("R1 message pair", v, 16'hA55A);
    wr(OFF_MSG, 16'h00FF, 2'b01);
    rd(OFF_MSG, v); check("R1 low byte enable", v, 16'hA5FF);
    rd(5'h1E, v); check("R1 unmapped reads 0", v, 16'h0000);
  endtask

  task automatic testGate();
    int s, r;
    logic [15:0] v;
    wr(OFF_TMR, 16'h0001); wr(OFF_CTA, 16'h0000);
    ticks(10, s, r); check("R3 timeout 1 no expiry", 16'(s), 16'd0);
    wr(OFF_TMR, 16'h0000); wr(OFF_CTA, 16'h0000);
    ticks(10, s, r); check("R3 timeout 0 no expiry", 16'(s), 16'd0);
    wr(OFF_TMR, 16'h0004); wr(OFF_CTA, 16'h0001);
    ticks(10, s, r); check("R3 halt no expiry", 16'(s), 16'd0);
    rd(OFF_STA, v); check("R3 status A untouched", v, 16'h0000);
  endtask

  task automatic testFirstStage();
    int s, r;
    logic [15:0] v;
    wr(OFF_CTA, 16'h0000);            // start, count 4
    ticks(1, s, r);                   // count 3
    wr(OFF_TMR, 16'h0001);
    wr(OFF_RLD, 16'hFC00);            // cannot run: stored, keeps counting
    rd(OFF_RLD, v); check("R7 upper stored, count live", v, 16'hFC03);
    wr(OFF_TMR, 16'h0004);
    ticks(2, s, r);
    rd(OFF_RLD, v); check("R7 remaining ticks", v, 16'hFC01);
    check("R4 no early expiry", 16'(s), 16'd0);
    ticks(1, s, r);
    check("R6 first expiry SMI", 16'(s), 16'd1);
    rd(OFF_STA, v); check("R4 status A timeout bit", v, 16'h0001);
    rd(OFF_RLD, v); check("R4 reloaded from timeout", v, 16'h0004);
    step(1'b0, '0, '0, 2'b00, 1'b0);
    check("R6 SMI is one cycle", {15'b0, smiPulse}, 16'h0);
  endtask

  task automatic testReboot();
    int s, r;
    logic [15:0] v;
    ticks(3, s, r);
    check("R5 no early reboot", 16'(r), 16'd0);
    ticks(1, s, r);
    check("R5 reboot pulse", 16'(r), 16'd1);
    check("R5 no SMI on reboot", 16'(s), 16'd0);
    rd(OFF_STB, v); check("R5 status B bits", v, 16'h0003);
    rd(OFF_RLD, v); check("R5 reload cleared", v, 16'h0000);
    ticks(8, s, r);
    check("R5 timer stopped", 16'(s + r), 16'd0);
  endtask

  task automatic testHoldOff();
    int s, r;
    logic [15:0] v;
    wr(OFF_STA, 16'h0000); wr(OFF_STB, 16'h0000);
    strapHi = 1'b1;
    wr(OFF_CTA, 16'h0000);
    ticks(8, s, r);
    check("R5 strap blocks reboot", 16'(r), 16'd0);
    check("R5 strap second expiry SMI", 16'(s), 16'd2);
    rd(OFF_STB, v); check("R5 status B set under strap", v, 16'h0003);
    strapHi = 1'b0; noRebootCtl = 1'b1;
    ticks(8, s, r);
    check("R5 no-reboot control blocks", 16'(r), 16'd0);
    noRebootCtl = 1'b0;
  endtask

  task automatic testReloadWrite();
    int s, r;
    logic [15:0] v;
    ticks(4, s, r);                   // first-stage expiry
    check("R8 first expiry before reload", 16'(s), 16'd1);
    wr(OFF_RLD, 16'h0000);            // clears consecutive count
    ticks(4, s, r);
    check("R8 reload write prevents reboot", 16'(r), 16'd0);
    check("R8 expiry after reload", 16'(s), 16'd1);
    wr(OFF_RLD, 16'h0000);
    ticks(2, s, r);
    rd(OFF_RLD, v); check("R8 restarted count", v, 16'h0002);
    wr(OFF_CTA, 16'h0001);
    wr(OFF_RLD, 16'h1234);
    rd(OFF_RLD, v); check("R8 halted stores value", v, 16'h1234);
  endtask

  task automatic testSmiEnable();
    int s, r;
    logic [15:0] v;
    wr(OFF_STA, 16'h0000);
    smiWdogEn = 1'b0;
    wr(OFF_RLD, 16'h0000);
    wr(OFF_CTA, 16'h0000);
    ticks(4, s, r);
    check("R6 SMI masked", 16'(s), 16'd0);
    rd(OFF_STA, v); check("R6 status still set", v, 16'h0001);
    wr(OFF_STA, 16'h0000);
  endtask

  task automatic testMailbox();
    logic [15:0] v;
    wr(OFF_MBOX, 16'h00C3, 2'b01);
    check("R9 in-byte SMI unconditional", {15'b0, smiPulse}, 16'h1);
    rd(OFF_STA, v); check("R9 software SMI bit", v, 16'h0002);
    wr(OFF_MBOX, 16'h5A00, 2'b10);
    check("R10 out-byte no SMI", {15'b0, smiPulse}, 16'h0);
    rd(OFF_STA, v); check("R10 interrupt bit", v, 16'h0006);
    rd(OFF_MBOX, v); check("R9 R10 mailbox bytes", v, 16'h5AC3);
    smiWdogEn = 1'b1;
  endtask

  task automatic testLock();
    int s, r;
    logic [15:0] v;
    wr(OFF_CTA, 16'h0002);
    wr(OFF_CTA, 16'h0000);
    rd(OFF_CTA, v); check("R11 lock sticky", v, 16'h0002);
    wr(OFF_CTA, 16'h0001);
    rd(OFF_CTA, v); check("R11 halt with lock", v, 16'h0003);
    ticks(10, s, r); check("R11 control write stops timer", 16'(s + r), 16'd0);
  endtask

  task automatic testMask();
    logic [15:0] v;
    wr(OFF_STA, 16'hFFFF); rd(OFF_STA, v); check("R13 status A mask", v, 16'h0007);
    wr(OFF_STB, 16'hFFFF); rd(OFF_STB, v); check("R13 status B mask", v, 16'h0003);
    wr(OFF_STA, 16'h0001); rd(OFF_STA, v); check("R13 direct write", v, 16'h0001);
    wr(OFF_STA, 16'h0000); wr(OFF_STB, 16'h0000);
  endtask

  task automatic testCollide();
    int s, r;
    logic [15:0] v;
    wr(OFF_CTA, 16'h0000);            // lock kept, halt cleared, count 4
    wr(OFF_RLD, 16'h0000);
    ticks(3, s, r);
    step(1'b1, OFF_MBOX, 16'h0011, 2'b01, 1'b1);
    check("R12 merged SMI pulse", {15'b0, smiPulse}, 16'h1);
    step(1'b0, '0, '0, 2'b00, 1'b0);
    check("R12 merged SMI one cycle", {15'b0, smiPulse}, 16'h0);
    rd(OFF_STA, v); check("R12 both status bits", v, 16'h0003);
    wr(OFF_STA, 16'h0000);
    wr(OFF_RLD, 16'h0000);
    ticks(3, s, r);
    step(1'b1, OFF_RLD, 16'h0000, 2'b11, 1'b1);
    check("R12 reload drops expiry SMI", {15'b0, smiPulse}, 16'h0);
    rd(OFF_STA, v); check("R12 reload drops expiry status", v, 16'h0000);
    rd(OFF_RLD, v); check("R12 reload full count", v, 16'h0004);
    ticks(3, s, r);
    step(1'b1, OFF_STA, 16'h0000, 2'b11, 1'b1);
    rd(OFF_STA, v); check("R12 hardware set beats write", v, 16'h0001);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMap();
    testGate();
    testFirstStage();
    testReboot();
    testHoldOff();
    testReloadWrite();
    testSmiEnable();
    testMailbox();
    testLock();
    testMask();
    testCollide();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule